// File: doc/BRIEF.md
# Framebuffer Aperture Address Comparator

This block decides whether a host memory cycle on a 32-bit local bus belongs to the graphics controller's video memory. Board glue logic outside the chip pre-decodes the high address lines into three segment-select inputs. The block compares these inputs, together with host address bits 23 and 22, against a software-programmed compare register. When they match, and the cycle is a memory cycle, it raises a select output and presents the byte offset inside the claimed window.

Software programs the block through a CRTC-style pair of I/O ports: an index port and a data port. It has two decode modes. In banked mode, the legacy 128 KB window at A0000–BFFFF inside the matched 1 MB area is claimed, and address bits 21:20 must be zero. In linear mode, the whole 4 MB region selected by the compare is claimed. The glue logic often inverts address bits 26:24 before they reach the segment inputs. In that case software writes (base / 4 MB) XOR 0x1C to place the linear window.

A build parameter selects an ISA-strap variant. In that variant the segment inputs are ignored and only compare bits 1:0 take part in the decode.

Top module: `fb_aperture_decode`

## Requirements
- R1: After reset the index register reads 0x00, the compare register (index 0x30) reads 0x1C, and the mode register (index 0x36) reads 0x00. Linear mode is therefore off, and the block claims segment inputs 111 with address bits 23:22 at 00.
- R2: A write to port 0x3D4 loads the 8-bit index. A write to port 0x3D5 with index 0x30 loads data bits 5:0 into the compare register. The compare register reads back on 0x3D5 with bits 7:6 zero.
- R3: A write to 0x3D5 with index 0x36 loads data bit 0 as the linear-mode enable (1 = linear). This register reads back with bits 7:1 zero.
- R4: When mem_cycle is 0 (an I/O cycle), mem_sel is 0 and win_offset is 0 for any address and segment value.
- R5: Banked mode, local-bus build: mem_sel is 1 exactly when seg_in equals compare bits 4:2, address bits 23:22 equal compare bits 1:0, address bits 21:20 are 00, and address bits 19:17 are 101 (the A0000–BFFFF window).
- R6: Linear mode, local-bus build: mem_sel is 1 exactly when seg_in equals compare bits 4:2 and address bits 23:22 equal compare bits 1:0, whatever the value of address bits 21:0.
- R7: While mem_sel is 1, win_offset is the address minus 0xA0000 (address bits 16:0, zero-extended) in banked mode, and address bits 21:0 in linear mode. While mem_sel is 0, win_offset is 0.
- R8: mem_sel and win_offset follow the address-phase inputs in the same cycle. A register write changes the decode from the clock edge that captures it onward, and not before that edge.
- R9: With inverting glue feeding seg_in from address bits 26:24, writing (base / 4 MB) XOR 0x1C places the linear window at base. For example, 0x0D claims 68 MB to 72 MB.
- R10: In the ISA-strap build, seg_in is ignored. Linear mode claims the 4 MB region whose address bits 23:22 equal compare bits 1:0 (base 0, 4, 8 or 12 MB). Banked mode treats bits 1:0 as zero and claims A0000–BFFFF only when address bits 23:20 are zero.
- R11: Writes to any other port, or to 0x3D5 with any other index, leave the compare and mode registers unchanged. Reads of 0x3D5 at any other index return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_wr_en | input | 1 | I/O write strobe, sampled on the clock edge |
| io_rd_en | input | 1 | I/O read strobe; read data is combinational |
| io_addr | input | 16 | I/O port address |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data (0 when not addressed) |
| mem_cycle | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| seg_in | input | 3 | Pre-decoded segment inputs from board glue, bit 2 compared to compare bit 4 |
| bus_addr | input | 24 | Host address bits 23:0 of the current cycle |
| mem_sel | output | 1 | Cycle claimed by the video memory aperture |
| win_offset | output | 22 | Byte offset inside the claimed window |

## Verification
The decode outputs are combinational, so every memory vector is applied after a falling clock edge and checked 1 ns later, in the same cycle. Reads on the data port are likewise checked within the cycle in which they are presented. A register write is held across one rising edge. The bench checks the decode just before that edge, where the old setting must still apply, and again after it, where the new setting must apply. This pins down the one-cycle latency of R8.

// File: rtl/fb_ap_pkg.sv
// Package: shared constants and the configuration record for the
// framebuffer aperture comparator. Assumes a 16-bit I/O space and
// byte-wide I/O data.
package fb_ap_pkg;

    localparam int unsigned IO_AW = 16;
    localparam int unsigned IO_DW = 8;
    localparam int unsigned CMP_REG_W = 6;

    localparam logic [IO_AW-1:0] PORT_INDEX = 16'h03D4;
    localparam logic [IO_AW-1:0] PORT_DATA  = 16'h03D5;

    localparam logic [IO_DW-1:0] IDX_COMPARE = 8'h30;
    localparam logic [IO_DW-1:0] IDX_MODE    = 8'h36;

    localparam logic [CMP_REG_W-1:0] CMP_RESET = 6'h1C;

    // Configuration held by the register block
    typedef struct packed {
        logic [CMP_REG_W-1:0] cmp;
        logic                 lin_en;
    } ap_cfg_t;

endpackage

// File: rtl/fb_ap_cfg_regs.sv
// Index/data register file. Holds the index, the compare value and
// the linear-mode enable. Writes land on the clock edge; reads are
// combinational. Assumes at most one strobe per cycle.
module fb_ap_cfg_regs
    import fb_ap_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             io_wr_en,
    input  logic             io_rd_en,
    input  logic [IO_AW-1:0] io_addr,
    input  logic [IO_DW-1:0] io_wdata,
    output logic [IO_DW-1:0] io_rdata,
    output logic [IO_DW-1:0] index_q,
    output ap_cfg_t          cfg_q
);

    localparam int unsigned PAD_W = IO_DW - CMP_REG_W;

    logic hit_index_port;
    logic hit_data_port;
    logic sel_cmp;
    logic sel_mode;

    // Port and index decode
    always_comb begin
        hit_index_port = (io_addr == PORT_INDEX);
        hit_data_port  = (io_addr == PORT_DATA);
        sel_cmp        = hit_data_port && (index_q == IDX_COMPARE);
        sel_mode       = hit_data_port && (index_q == IDX_MODE);
    end

    // Index register
    always_ff @(posedge clk) begin
        if (!rst_n)
            index_q <= '0;
        else if (io_wr_en && hit_index_port)
            index_q <= io_wdata;
    end

    // Compare register
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q.cmp <= CMP_RESET;
        else if (io_wr_en && sel_cmp)
            cfg_q.cmp <= io_wdata[CMP_REG_W-1:0];
    end

    // Linear-mode enable
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q.lin_en <= 1'b0;
        else if (io_wr_en && sel_mode)
            cfg_q.lin_en <= io_wdata[0];
    end

    // Read-back mux
    always_comb begin
        io_rdata = '0;
        if (io_rd_en) begin
            if (hit_index_port)
                io_rdata = index_q;
            else if (sel_cmp)
                io_rdata = {{PAD_W{1'b0}}, cfg_q.cmp};
            else if (sel_mode)
                io_rdata = {{(IO_DW-1){1'b0}}, cfg_q.lin_en};
        end
    end

endmodule

// File: rtl/fb_ap_match.sv
// Segment and upper-address comparator. Produces the region match
// for the current cycle. The local-bus build compares the segment
// inputs and the top address bits. The ISA build ignores the segment
// inputs and, in banked mode, treats the low compare bits as zero.
module fb_ap_match #(
    parameter int unsigned SEG_W  = 3,
    parameter int unsigned HI_W   = 2,
    parameter bit          IS_ISA = 1'b0
) (
    input  logic [SEG_W+HI_W-1:0] cmp,
    input  logic                  lin_en,
    input  logic [SEG_W-1:0]      seg_in,
    input  logic [HI_W-1:0]       addr_hi,
    output logic                  region_hit
);

    localparam int unsigned CMP_W = SEG_W + HI_W;

    generate
        if (IS_ISA) begin : g_isa
            logic [HI_W-1:0] want_hi;
            logic            unused_seg;
            // Banked mode forces the low compare bits to zero
            always_comb begin
                want_hi    = lin_en ? cmp[HI_W-1:0] : '0;
                region_hit = (addr_hi == want_hi);
                unused_seg = ^{seg_in, cmp[CMP_W-1:HI_W]};
            end
        end else begin : g_lbus
            // Both fields must agree
            always_comb begin
                region_hit = (seg_in == cmp[CMP_W-1:HI_W])
                          && (addr_hi == cmp[HI_W-1:0]);
            end
        end
    endgenerate

endmodule

// File: rtl/fb_ap_window.sv
// Window shaper. Given the region match, applies the mode's extra
// address rules (banked: 1 MB sub-area zero and A0000-BFFFF window)
// and forms the offset inside the claimed window.
module fb_ap_window #(
    parameter int unsigned LIN_LOG2 = 22,
    parameter int unsigned MB_LOG2  = 20,
    parameter int unsigned LEG_LOG2 = 17,
    parameter logic [2:0]  LEG_TAG  = 3'b101
) (
    input  logic                mem_cycle,
    input  logic                lin_en,
    input  logic                region_hit,
    input  logic [LIN_LOG2-1:0] addr_lo,
    output logic                sel,
    output logic [LIN_LOG2-1:0] offset
);

    localparam int unsigned SUB_W = LIN_LOG2 - MB_LOG2;
    localparam int unsigned TAG_W = MB_LOG2 - LEG_LOG2;

    logic in_legacy;

    // Banked-mode address rules
    always_comb begin
        in_legacy = (addr_lo[LIN_LOG2-1:MB_LOG2] == {SUB_W{1'b0}})
                 && (addr_lo[MB_LOG2-1:LEG_LOG2] == LEG_TAG[TAG_W-1:0]);
    end

    // Select and offset
    always_comb begin
        sel    = mem_cycle && region_hit && (lin_en || in_legacy);
        offset = '0;
        if (sel) begin
            if (lin_en)
                offset = addr_lo;
            else
                offset = {{(LIN_LOG2-LEG_LOG2){1'b0}}, addr_lo[LEG_LOG2-1:0]};
        end
    end

endmodule

// File: rtl/fb_aperture_decode.sv
// Top: framebuffer aperture comparator. Software sets it through the
// index/data ports. Each memory cycle is checked against the
// compare register and the mode. Assumes the board supplies
// pre-decoded segment inputs and address bits 23:0.
module fb_aperture_decode
    import fb_ap_pkg::*;
#(
    parameter int unsigned ADDR_W   = 24,
    parameter int unsigned SEG_W    = 3,
    parameter int unsigned LIN_LOG2 = 22,
    parameter bit          IS_ISA   = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                io_wr_en,
    input  logic                io_rd_en,
    input  logic [15:0]         io_addr,
    input  logic [7:0]          io_wdata,
    output logic [7:0]          io_rdata,
    input  logic                mem_cycle,
    input  logic [SEG_W-1:0]    seg_in,
    input  logic [ADDR_W-1:0]   bus_addr,
    output logic                mem_sel,
    output logic [LIN_LOG2-1:0] win_offset
);

    localparam int unsigned HI_W  = ADDR_W - LIN_LOG2;
    localparam int unsigned CMP_W = SEG_W + HI_W;

    ap_cfg_t          cfg;
    logic [IO_DW-1:0] cur_index;
    logic             region_hit;
    logic             unused_cmp;

    // Spare compare bits only feed read-back
    always_comb unused_cmp = ^cfg.cmp[CMP_REG_W-1:CMP_W];

    fb_ap_cfg_regs u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .io_wr_en (io_wr_en),
        .io_rd_en (io_rd_en),
        .io_addr  (io_addr),
        .io_wdata (io_wdata),
        .io_rdata (io_rdata),
        .index_q  (cur_index),
        .cfg_q    (cfg)
    );

    fb_ap_match #(
        .SEG_W  (SEG_W),
        .HI_W   (HI_W),
        .IS_ISA (IS_ISA)
    ) u_match (
        .cmp        (cfg.cmp[CMP_W-1:0]),
        .lin_en     (cfg.lin_en),
        .seg_in     (seg_in),
        .addr_hi    (bus_addr[ADDR_W-1:LIN_LOG2]),
        .region_hit (region_hit)
    );

    fb_ap_window #(
        .LIN_LOG2 (LIN_LOG2)
    ) u_window (
        .mem_cycle  (mem_cycle),
        .lin_en     (cfg.lin_en),
        .region_hit (region_hit),
        .addr_lo    (bus_addr[LIN_LOG2-1:0]),
        .sel        (mem_sel),
        .offset     (win_offset)
    );

endmodule

// File: rtl/fb_aperture_decode_chk.sv
// Checker for the aperture comparator, bound to every instance.
module fb_aperture_decode_chk #(
    parameter bit IS_ISA = 1'b0
) (
    input logic        clk,
    input logic        rst_n,
    input logic        io_wr_en,
    input logic [15:0] io_addr,
    input logic [7:0]  io_wdata,
    input logic [7:0]  cur_index,
    input logic [5:0]  cmp_q,
    input logic        lin_q,
    input logic        mem_cycle,
    input logic [2:0]  seg_in,
    input logic [23:0] bus_addr,
    input logic        mem_sel,
    input logic [21:0] win_offset
);

    // R1
    reset_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cmp_q == 6'h1C) && !lin_q && (cur_index == 8'h00));

    // R2
    cmp_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr_en && io_addr == 16'h03D5 && cur_index == 8'h30)
        |=> cmp_q == $past(io_wdata[5:0]));

    // R4
    io_cycle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cycle |-> !mem_sel && (win_offset == 22'd0));

    // R5
    banked_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_sel && !lin_q) |-> (bus_addr[21:20] == 2'b00)
                              && (bus_addr[19:17] == 3'b101));

    // R6
    linear_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_sel && lin_q && !IS_ISA) |-> (seg_in == cmp_q[4:2])
                                        && (bus_addr[23:22] == cmp_q[1:0]));

    // R7
    offset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_sel |-> win_offset == 22'd0);

    // R11
    other_port_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr_en && io_addr != 16'h03D5) |=> $stable(cmp_q) && $stable(lin_q));

endmodule

bind fb_aperture_decode fb_aperture_decode_chk #(.IS_ISA(IS_ISA)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .io_wr_en   (io_wr_en),
    .io_addr    (io_addr),
    .io_wdata   (io_wdata),
    .cur_index  (cur_index),
    .cmp_q      (cfg.cmp),
    .lin_q      (cfg.lin_en),
    .mem_cycle  (mem_cycle),
    .seg_in     (seg_in),
    .bus_addr   (bus_addr),
    .mem_sel    (mem_sel),
    .win_offset (win_offset)
);

// File: tb/fb_aperture_decode_bench.sv
// Bench: drives a local-bus instance and an ISA-strap instance from
// the same inputs and checks both against a bench model.
module fb_aperture_decode_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_wr_en = 1'b0;
    logic        io_rd_en = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  rd_lb, rd_isa;
    logic        mem_cycle = 1'b0;
    logic [2:0]  seg_in = '0;
    logic [23:0] bus_addr = '0;
    logic        sel_lb, sel_isa;
    logic [21:0] ofs_lb, ofs_isa;

    int n_vec = 0;
    int n_bad = 0;

    logic [5:0] m_cmp = 6'h1C;
    logic       m_lin = 1'b0;

    always #4 clk = ~clk;

    fb_aperture_decode u_fb_aperture_decode (
        .clk(clk), .rst_n(rst_n), .io_wr_en(io_wr_en), .io_rd_en(io_rd_en),
        .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(rd_lb),
        .mem_cycle(mem_cycle), .seg_in(seg_in), .bus_addr(bus_addr),
        .mem_sel(sel_lb), .win_offset(ofs_lb)
    );

    fb_aperture_decode #(.IS_ISA(1'b1)) u_fb_aperture_decode_isa (
        .clk(clk), .rst_n(rst_n), .io_wr_en(io_wr_en), .io_rd_en(io_rd_en),
        .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(rd_isa),
        .mem_cycle(mem_cycle), .seg_in(seg_in), .bus_addr(bus_addr),
        .mem_sel(sel_isa), .win_offset(ofs_isa)
    );

    function automatic bit exp_sel(bit isa, logic [5:0] c, bit lin,
                                   logic [2:0] s, logic [23:0] a, bit m);
        if (!m) return 1'b0;
        if (isa) begin
            if (lin) return a[23:22] == c[1:0];
            return (a[23:20] == 4'h0) && (a[19:17] == 3'b101);
        end
        if ((s != c[4:2]) || (a[23:22] != c[1:0])) return 1'b0;
        if (lin) return 1'b1;
        return (a[21:20] == 2'b00) && (a[19:17] == 3'b101);
    endfunction

    function automatic logic [21:0] exp_ofs(bit sel, bit lin, logic [23:0] a);
        if (!sel) return 22'd0;
        if (lin) return a[21:0];
        return {5'd0, a[16:0]};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic io_write(logic [15:0] a, logic [7:0] d);
        @(negedge clk);
        io_wr_en = 1'b1; io_addr = a; io_wdata = d;
        @(negedge clk);
        io_wr_en = 1'b0;
    endtask

    task automatic io_read(logic [15:0] a, string req, logic [7:0] exp);
        @(negedge clk);
        io_rd_en = 1'b1; io_addr = a;
        #1;
        check(req, {24'd0, rd_lb}, {24'd0, exp});
        check(req, {24'd0, rd_isa}, {24'd0, exp});
        io_rd_en = 1'b0;
    endtask

    task automatic set_cmp(logic [5:0] v);
        io_write(16'h03D4, 8'h30);
        io_write(16'h03D5, {2'b11, v});
        m_cmp = v;
    endtask

    task automatic set_lin(bit v);
        io_write(16'h03D4, 8'h36);
        io_write(16'h03D5, {7'h55, v});
        m_lin = v;
    endtask

    // Apply one memory vector and compare both builds
    task automatic mem_vec(string req, bit m, logic [2:0] s, logic [23:0] a);
        bit e_lb, e_isa;
        @(negedge clk);
        mem_cycle = m; seg_in = s; bus_addr = a;
        #1;
        e_lb  = exp_sel(1'b0, m_cmp, m_lin, s, a, m);
        e_isa = exp_sel(1'b1, m_cmp, m_lin, s, a, m);
        check(req, {31'd0, sel_lb}, {31'd0, e_lb});
        check(req, {10'd0, ofs_lb}, {10'd0, exp_ofs(e_lb, m_lin, a)});
        check({req, "/R10"}, {31'd0, sel_isa}, {31'd0, e_isa});
        check({req, "/R10"}, {10'd0, ofs_isa}, {10'd0, exp_ofs(e_isa, m_lin, a)});
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        io_read(16'h03D4, "R1", 8'h00);
        io_read(16'h03D5, "R1", 8'h00);
        mem_vec("R1", 1'b1, 3'b111, 24'h0A1234);
        check("R1", {31'd0, sel_lb}, 32'd1);

        // R2 compare write and read-back
        io_write(16'h03D4, 8'h30);
        io_read(16'h03D4, "R2", 8'h30);
        io_read(16'h03D5, "R2", 8'h1C);
        set_cmp(6'h2B);
        io_read(16'h03D5, "R2", 8'h2B);

        // R3 mode register
        set_lin(1'b1);
        io_read(16'h03D5, "R3", 8'h01);
        set_lin(1'b0);
        io_read(16'h03D5, "R3", 8'h00);

        // R11 other ports and indices
        io_write(16'h03D4, 8'h12);
        io_write(16'h03D5, 8'hFF);
        io_read(16'h03D5, "R11", 8'h00);
        io_write(16'h03C5, 8'h3F);
        io_write(16'h03D4, 8'h30);
        io_read(16'h03D5, "R11", 8'h2B);
        io_write(16'h03D4, 8'h36);
        io_read(16'h03D5, "R11", 8'h00);

        // R4 I/O cycle with a matching address
        set_cmp(6'h1C);
        mem_vec("R4", 1'b0, 3'b111, 24'h0A0000);

        // R5 banked corners
        mem_vec("R5", 1'b1, 3'b111, 24'h0A0000);
        mem_vec("R5", 1'b1, 3'b111, 24'h0BFFFF);
        mem_vec("R5", 1'b1, 3'b111, 24'h09FFFF);
        mem_vec("R5", 1'b1, 3'b111, 24'h0C0000);
        mem_vec("R5", 1'b1, 3'b111, 24'h1A0000);
        mem_vec("R5", 1'b1, 3'b110, 24'h0A0000);

        // R6/R7 linear mode at 4 MB
        set_cmp(6'h1D);
        set_lin(1'b1);
        mem_vec("R6", 1'b1, 3'b111, 24'h400000);
        mem_vec("R7", 1'b1, 3'b111, 24'h7FFFFF);
        mem_vec("R6", 1'b1, 3'b111, 24'h3FFFFF);
        mem_vec("R6", 1'b1, 3'b011, 24'h512345);

        // R9 inverting glue: 68 MB window with 0x0D
        set_cmp(6'h0D);
        for (int k = 0; k < 4; k++) begin
            logic [26:0] full;
            full = (k < 2) ? 27'h4400000 + 27'(k * 27'h1FFFFF) : 27'h4000000 + 27'(k);
            mem_vec("R9", 1'b1, ~full[26:24], full[23:0]);
        end
        check("R9", {31'd0, sel_lb}, 32'd0);

        // R8 write takes effect on the capturing edge
        io_write(16'h03D4, 8'h30);
        @(negedge clk);
        io_wr_en = 1'b1; io_addr = 16'h03D5; io_wdata = 8'h1C;
        mem_cycle = 1'b1; seg_in = 3'b111; bus_addr = 24'h123456;
        #1;
        check("R8", {31'd0, sel_lb}, 32'd0);
        @(posedge clk);
        #1;
        io_wr_en = 1'b0;
        m_cmp = 6'h1C;
        check("R8", {31'd0, sel_lb}, 32'd1);
        check("R8", {10'd0, ofs_lb}, {10'd0, 22'h123456});

        // R10 ISA banked forces low bits to zero
        set_lin(1'b0);
        set_cmp(6'h03);
        mem_vec("R10", 1'b1, 3'b000, 24'h0A8000);
        mem_vec("R10", 1'b1, 3'b000, 24'hCA8000);

        // Random mix
        for (int i = 0; i < 600; i++) begin
            logic [23:0] a;
            logic [2:0]  s;
            if (($urandom % 16) == 0) set_cmp(6'($urandom));
            if (($urandom % 24) == 0) set_lin(1'($urandom));
            a = 24'($urandom);
            s = 3'($urandom);
            if ($urandom % 2) begin
                s = m_cmp[4:2];
                a[23:22] = m_cmp[1:0];
            end
            if ($urandom % 2) a[21:17] = 5'b00101;
            mem_vec("R5/R6/R7", 1'($urandom % 8 != 0), s, a);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule